// File: doc/BRIEF.md
# Planar Cursor RAM Access Controller

This block holds a 64x64 cursor image with two bits per pixel. The image is kept as two separate bit-planes of 512 bytes each, so one byte address reaches eight pixels of one plane. A processor reaches both planes through a 10-bit address counter that steps by one after every cursor data access. The two upper counter bits come from a control register. The lower eight bits come from a byte write to the address port, and that write copies the control bits into the counter at the same time. The top counter bit picks the plane and the other nine pick the byte within it.

A block of cursor bytes is written or read by loading a start address once and then issuing a run of data accesses. Loading the address again at any point restarts the run from the new address. Reading the address back leaves the counter untouched. A second read port, separate from the processor side, serves the display logic: it takes a 9-bit byte address and returns the byte of both planes for that address together.

Top module: `cursor_ram_ctl`

## Requirements
- R1: After reset, a read of the control register and a read of the address low byte both return 0, and `cpu_rdata` is 0.
- R2: A write with `cpu_sel` = 2'b00 (address low byte) loads the counter with {control bits [1:0], written byte}. A write with `cpu_sel` = 2'b10 (control) changes only the stored upper bits and does not move the counter.
- R3: A write with `cpu_sel` = 2'b01 (cursor data) stores the byte in plane `counter[9]` at byte `counter[8:0]`, then increments the counter by one.
- R4: A read with `cpu_sel` = 2'b01 places the byte at the current counter address on `cpu_rdata` at the clock edge that samples the read, then increments the counter by one.
- R5: The counter wraps from 1023 to 0, so a run continues from the last byte of plane 1 to the first byte of plane 0. The control bits are not changed by the wrap.
- R6: A write to the address low byte in the middle of a run makes the next data access use the written address, and stepping continues from there.
- R7: A read with `cpu_sel` = 2'b00 returns counter bits [7:0] and does not change the counter, so the following data access uses the same address.
- R8: A control read returns the two upper bits in [1:0] and 0 in all other bits. Bit 2, the unsupported small-cursor select, has no effect when written and always reads as 0.
- R9: The display port returns plane 0 on `disp_plane0` and plane 1 on `disp_plane1` for byte `disp_addr`, one clock after the address is sampled. It does not depend on the counter.
- R10: When `cpu_wr` and `cpu_rd` are high in the same cycle, only the write takes place. `cpu_rdata` keeps its value and the counter steps only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | Processor write strobe, one cycle per access |
| cpu_rd | input | 1 | Processor read strobe, one cycle per access |
| cpu_sel | input | 2 | Target: 00 address low byte, 01 cursor data, 10 control, 11 unused |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, registered at the sampling edge |
| disp_addr | input | 9 | Display byte address within a plane |
| disp_plane0 | output | 8 | Plane 0 byte for the display address |
| disp_plane1 | output | 8 | Plane 1 byte for the display address |

## Verification
The cases that are hardest to reach from the ports are a reload in the middle of a run and the wrap across the plane boundary. In both, the counter itself is never visible, only the addresses where bytes land. The bench starts a run, reads the low byte in the middle of it, then writes a new low byte. It then checks through the display port which plane bytes were written. For the wrap it loads 1022, writes three bytes, and confirms that the third one appears at byte 0 of plane 0 while the control bits read back unchanged.

// File: rtl/cur_pkg.sv
package cur_pkg;

    localparam int CUR_DW       = 8;
    localparam int CUR_PLANE_AW = 9;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'b00,
        SEL_DATA    = 2'b01,
        SEL_CTRL    = 2'b10,
        SEL_NONE    = 2'b11
    } port_sel_e;

    // Plane index carried by a full counter value (top bit).
    function automatic logic plane_of(input logic [CUR_PLANE_AW:0] a);
        return a[CUR_PLANE_AW];
    endfunction

endpackage

// File: rtl/cur_addr_ctr.sv
module cur_addr_ctr #(
    parameter int DW    = 8,
    parameter int CNT_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_hi,
    input  logic               ld_lo,
    input  logic               step,
    input  logic [DW-1:0]      din,
    output logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-DW-1:0] hi
);
    localparam int HI_W = CNT_W - DW;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            hi  <= '0;
        end else begin
            if (ld_hi)
                hi <= din[HI_W-1:0];
            // A low-byte load overrides any pending step and restarts the run.
            if (ld_lo)
                cnt <= {hi, din};
            else if (step)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cur_plane_mem.sv
module cur_plane_mem #(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] cpu_addr,
    output logic [DW-1:0] cpu_q,
    input  logic [AW-1:0] disp_addr,
    output logic [DW-1:0] disp_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        disp_q <= mem[disp_addr];
    end

    assign cpu_q = mem[cpu_addr];
endmodule

// File: rtl/cursor_ram_ctl.sv
module cursor_ram_ctl
    import cur_pkg::*;
#(
    parameter int DW       = CUR_DW,
    parameter int PLANE_AW = CUR_PLANE_AW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_wr,
    input  logic                cpu_rd,
    input  logic [1:0]          cpu_sel,
    input  logic [DW-1:0]       cpu_wdata,
    output logic [DW-1:0]       cpu_rdata,
    input  logic [PLANE_AW-1:0] disp_addr,
    output logic [DW-1:0]       disp_plane0,
    output logic [DW-1:0]       disp_plane1
);
    localparam int N_PLANES = 2;
    localparam int CNT_W    = PLANE_AW + $clog2(N_PLANES);
    localparam int HI_W     = CNT_W - DW;

    port_sel_e sel;
    assign sel = port_sel_e'(cpu_sel);

    logic rd_only;
    logic wr_lo, wr_ctrl, wr_data, rd_data;
    assign rd_only = cpu_rd && !cpu_wr;
    assign wr_lo   = cpu_wr && (sel == SEL_ADDR_LO);
    assign wr_ctrl = cpu_wr && (sel == SEL_CTRL);
    assign wr_data = cpu_wr && (sel == SEL_DATA);
    assign rd_data = rd_only && (sel == SEL_DATA);

    logic [CNT_W-1:0] cnt;
    logic [HI_W-1:0]  hi;

    cur_addr_ctr #(.DW(DW), .CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .ld_hi (wr_ctrl),
        .ld_lo (wr_lo),
        .step  (wr_data || rd_data),
        .din   (cpu_wdata),
        .cnt   (cnt),
        .hi    (hi)
    );

    logic            cur_plane;
    logic [DW-1:0]   cpu_q  [N_PLANES];
    logic [DW-1:0]   disp_q [N_PLANES];

    assign cur_plane = plane_of(cnt);

    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        cur_plane_mem #(.DW(DW), .AW(PLANE_AW)) u_mem (
            .clk       (clk),
            .we        (wr_data && (cur_plane == 1'(p))),
            .waddr     (cnt[PLANE_AW-1:0]),
            .wdata     (cpu_wdata),
            .cpu_addr  (cnt[PLANE_AW-1:0]),
            .cpu_q     (cpu_q[p]),
            .disp_addr (disp_addr),
            .disp_q    (disp_q[p])
        );
    end

    assign disp_plane0 = disp_q[0];
    assign disp_plane1 = disp_q[1];

    logic [DW-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_ADDR_LO: rd_mux = cnt[DW-1:0];
            SEL_DATA:    rd_mux = cpu_q[cur_plane];
            SEL_CTRL:    rd_mux[HI_W-1:0] = hi;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cpu_rdata <= '0;
        else if (rd_only)
            cpu_rdata <= rd_mux;
    end
endmodule

// File: rtl/cursor_ram_ctl_chk.sv
module cursor_ram_ctl_chk #(
    parameter int DW    = 8,
    parameter int CNT_W = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cpu_wr,
    input logic                 cpu_rd,
    input logic [1:0]           cpu_sel,
    input logic [DW-1:0]        cpu_wdata,
    input logic [DW-1:0]        cpu_rdata,
    input logic [CNT_W-1:0]     cnt,
    input logic [CNT_W-DW-1:0]  hi
);
    localparam int HI_W = CNT_W - DW;

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_sel == 2'b00) |=> cnt == {$past(hi), $past(cpu_wdata)});

    p_ctrl_no_move_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_sel == 2'b10) |=> $stable(cnt));

    p_wr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_sel == 2'b01) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    p_rd_step_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !cpu_wr && cpu_sel == 2'b01) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_sel == 2'b01 && cnt == '1) |=> cnt == '0);

    p_addr_rd_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !cpu_wr && cpu_sel == 2'b00)
        |=> (cpu_rdata == $past(cnt[DW-1:0])) && $stable(cnt));

    p_ctrl_rd_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !cpu_wr && cpu_sel == 2'b10) |=> cpu_rdata[DW-1:HI_W] == '0);

    p_prio_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_rd) |=> $stable(cpu_rdata));
endmodule

bind cursor_ram_ctl cursor_ram_ctl_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_sel   (cpu_sel),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cnt       (cnt),
    .hi        (hi)
);

// File: tb/tb_cursor_ram_ctl.sv
module tb_cursor_ram_ctl;
    localparam logic [1:0] S_LO = 2'b00, S_DATA = 2'b01, S_CTRL = 2'b10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [1:0] cpu_sel = 2'b00;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [8:0] disp_addr = '0;
    logic [7:0] disp_plane0, disp_plane1;

    cursor_ram_ctl dut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .disp_addr(disp_addr), .disp_plane0(disp_plane0), .disp_plane1(disp_plane1)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] mdl [1024];
    logic [9:0] cnt_m = '0;
    logic [1:0] hi_m  = '0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        case (sel)
            S_LO:   cnt_m = {hi_m, d};
            S_DATA: begin mdl[cnt_m] = d; cnt_m = cnt_m + 1'b1; end
            S_CTRL: hi_m = d[1:0];
            default: ;
        endcase
    endtask

    task automatic rd_chk(input logic [1:0] sel, input string req);
        logic [7:0] exp;
        case (sel)
            S_LO:    exp = cnt_m[7:0];
            S_DATA:  exp = mdl[cnt_m];
            S_CTRL:  exp = {6'b0, hi_m};
            default: exp = 8'h00;
        endcase
        @(negedge clk);
        cpu_sel = sel; cpu_rd = 1'b1;
        @(posedge clk); #1;
        cpu_rd = 1'b0;
        if (sel == S_DATA) cnt_m = cnt_m + 1'b1;
        chk(req, cpu_rdata, exp);
    endtask

    task automatic disp_chk(input logic [8:0] a, input bit c0, input bit c1, input string req);
        @(negedge clk);
        disp_addr = a;
        @(posedge clk); #1;
        if (c0) chk(req, disp_plane0, mdl[{1'b0, a}]);
        if (c1) chk(req, disp_plane1, mdl[{1'b1, a}]);
    endtask

    task automatic t_reset;
        chk("R1", cpu_rdata, 8'h00);
        rd_chk(S_CTRL, "R1");
        rd_chk(S_LO, "R1");
    endtask

    task automatic t_load;
        bus_wr(S_CTRL, 8'h01);
        bus_wr(S_LO, 8'h34);
        rd_chk(S_LO, "R2");
        bus_wr(S_CTRL, 8'h02);          // must not move the counter
        rd_chk(S_LO, "R2");
        bus_wr(S_CTRL, 8'h01);
        bus_wr(S_DATA, 8'h5A);          // lands at plane 0 byte 0x134
        disp_chk(9'h134, 1'b1, 1'b0, "R2");
    endtask

    task automatic t_run;
        bus_wr(S_CTRL, 8'h02);
        bus_wr(S_LO, 8'h10);
        for (int i = 0; i < 4; i++) bus_wr(S_DATA, 8'hA0 + 8'(i));
        rd_chk(S_LO, "R3");
        disp_chk(9'h012, 1'b0, 1'b1, "R3");
        bus_wr(S_LO, 8'h10);
        for (int i = 0; i < 4; i++) rd_chk(S_DATA, "R4");
        rd_chk(S_LO, "R4");
    endtask

    task automatic t_planes;
        bus_wr(S_CTRL, 8'h00);
        bus_wr(S_LO, 8'h77);
        bus_wr(S_DATA, 8'h11);
        bus_wr(S_CTRL, 8'h02);
        bus_wr(S_LO, 8'h77);
        bus_wr(S_DATA, 8'h22);
        disp_chk(9'h077, 1'b1, 1'b1, "R9");
        disp_chk(9'h012, 1'b0, 1'b1, "R9");
    endtask

    task automatic t_wrap;
        bus_wr(S_CTRL, 8'h03);
        bus_wr(S_LO, 8'hFE);
        bus_wr(S_DATA, 8'hB1);
        bus_wr(S_DATA, 8'hB2);
        bus_wr(S_DATA, 8'hB3);
        rd_chk(S_LO, "R5");
        rd_chk(S_CTRL, "R5");
        disp_chk(9'h1FF, 1'b0, 1'b1, "R5");
        disp_chk(9'h000, 1'b1, 1'b0, "R5");
        bus_wr(S_LO, 8'hFF);
        rd_chk(S_DATA, "R5");
        rd_chk(S_DATA, "R5");
    endtask

    task automatic t_restart;
        bus_wr(S_CTRL, 8'h00);
        bus_wr(S_LO, 8'h40);
        bus_wr(S_DATA, 8'h61);
        bus_wr(S_DATA, 8'h62);
        rd_chk(S_LO, "R7");
        bus_wr(S_DATA, 8'h63);          // must land at 0x042
        disp_chk(9'h042, 1'b1, 1'b0, "R7");
        bus_wr(S_LO, 8'h80);
        bus_wr(S_DATA, 8'h99);
        rd_chk(S_LO, "R6");
        disp_chk(9'h080, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_ctrl_bits;
        bus_wr(S_CTRL, 8'hFF);
        rd_chk(S_CTRL, "R8");
        bus_wr(S_LO, 8'h05);
        bus_wr(S_DATA, 8'hC3);          // plane 1 byte 0x105
        disp_chk(9'h105, 1'b0, 1'b1, "R8");
        bus_wr(S_CTRL, 8'h04);          // only the dead bit set
        rd_chk(S_CTRL, "R8");
    endtask

    task automatic t_prio;
        bus_wr(S_CTRL, 8'h00);
        bus_wr(S_LO, 8'hC0);
        rd_chk(S_LO, "R10");            // cpu_rdata now 0xC0
        @(negedge clk);
        cpu_sel = S_DATA; cpu_wdata = 8'h3C; cpu_wr = 1'b1; cpu_rd = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        mdl[cnt_m] = 8'h3C; cnt_m = cnt_m + 1'b1;
        chk("R10", cpu_rdata, 8'hC0);
        rd_chk(S_LO, "R10");
        disp_chk(9'h0C0, 1'b1, 1'b0, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load();
        t_run();
        t_planes();
        t_wrap();
        t_restart();
        t_ctrl_bits();
        t_prio();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule